// File: doc/BRIEF.md
# Carry-Save Radix-2 SRT Divider

This block divides a signed dividend by a normalized unsigned divisor, producing a signed quotient of P fractional-weight bits and a signed remainder. The partial remainder is kept as two words, a sum word and a carry word. Each iteration therefore costs one row of full adders. The next quotient digit, taken from the set {-1, 0, +1}, is chosen from a 4-bit sum of the top four bits of both words. This means no carry has to ripple across the full datapath width inside the loop.

A one-cycle `start` pulse captures the operands while the block is idle. The block then spends P cycles producing one digit per cycle. One further cycle does the following work:
- resolves the redundant remainder with a single carry-propagate addition,
- forms the quotient as the positive-digit vector minus the negative-digit vector,
- applies a sign fix so that the remainder never disagrees in sign with the dividend.

The result is presented together with a one-cycle `done` pulse. The result is held until the next completion.

The dividend X is an (N+1)-bit two's complement value with -Y ≤ X < Y. The divisor Y is N bits wide with its top bit set. The result is equivalent to integer division of X·2^P by Y, truncated toward zero.

Top module: `srt_cs_divider`

## Requirements
- R1: A `start` high at a rising edge while the block is idle captures `dividend` and `divisor`. `done` goes high after the (P+1)-th rising edge following that edge, and not earlier.
- R2: `done` is high for exactly one cycle per accepted operation.
- R3: A `start` pulse raised while an operation is in progress is ignored. That operation's result and completion timing are unchanged.
- R4: At completion, `quotient` (P+1-bit two's complement) and `remainder` (N+1-bit two's complement) satisfy X·2^P = quotient·Y + remainder exactly.
- R5: For X ≥ 0, the completed remainder satisfies 0 ≤ remainder < Y.
- R6: For X < 0, the completed remainder satisfies -Y < remainder ≤ 0.
- R7: The boundary cases produce these results:
  - X = -Y gives quotient -2^P and remainder 0.
  - X = 0 gives quotient 0 and remainder 0.
  - X = Y-1 gives a quotient of 2^P-1 or less.
  - The divisor may be 2^(N-1) or 2^N-1.
- R8: After reset, `quotient`, `remainder` and `done` are 0. `quotient` and `remainder` change only in a cycle where `done` is high.
- R9: A `start` high in the same cycle as `done` is accepted, so operations can run back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | N+1 | Signed dividend X, -Y ≤ X < Y |
| divisor | input | N | Normalized divisor Y, top bit set |
| quotient | output | P+1 | Signed quotient, held between completions |
| remainder | output | N+1 | Signed remainder, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: the result registers loading with `done`, and a new operation being accepted. This cycle is provoked by raising `start` with fresh operands in the very cycle that `done` is observed high.

The overlap is judged in two ways. First, the first result must stay on the outputs, unchanged, throughout the whole second operation. Second, the second result must appear exactly P+1 edges after acceptance and match the integer reference.

// File: rtl/srt_cs_pkg.sv
package srt_cs_pkg;

    // Signed quotient digit of one iteration.
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b01,
        DIG_NEG  = 2'b10
    } digit_e;

    // Sequencer phases.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ITER = 2'b01,
        PH_FIX  = 2'b10
    } phase_e;

    // t is the truncated estimate of the doubled remainder, counted in units
    // of 2^(N-1) and read as a 4-bit two's complement number.
    function automatic digit_e pick_digit(input logic [3:0] t);
        digit_e d;
        case (t)
            4'd0, 4'd1, 4'd2, 4'd3:      d = DIG_POS;
            4'd11, 4'd12, 4'd13, 4'd14:  d = DIG_NEG;
            default:                     d = DIG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/srt_digit_sel.sv
module srt_digit_sel
    import srt_cs_pkg::*;
(
    input  logic [3:0] s_top,
    input  logic [3:0] c_top,
    output digit_e     dig
);
    logic [3:0] est;

    always_comb begin
        est = s_top + c_top;
        dig = pick_digit(est);
    end
endmodule

// File: rtl/srt_csa_row.sv
module srt_csa_row
    import srt_cs_pkg::*;
#(
    parameter int N = 8,
    localparam int W = N + 3
) (
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] c_in,
    input  logic [N-1:0] y,
    input  digit_e       dig,
    output logic [W-1:0] s_nxt,
    output logic [W-1:0] c_nxt
);
    localparam int EXT = W - N;

    logic [W-1:0] addend;
    logic [W-1:0] sum_b;
    logic [W-1:0] maj_b;
    logic [W-1:0] carry_w;
    logic         plus_one;

    always_comb begin
        case (dig)
            DIG_POS: addend = {{EXT{1'b1}}, ~y};
            DIG_NEG: addend = {{EXT{1'b0}}, y};
            default: addend = '0;
        endcase
    end

    // The +1 that completes -Y goes into the carry LSB, which the shift leaves empty.
    assign plus_one = (dig == DIG_POS);

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_b[i] = s_in[i] ^ c_in[i] ^ addend[i];
        assign maj_b[i] = (s_in[i] & c_in[i]) | (s_in[i] & addend[i]) | (c_in[i] & addend[i]);
    end

    assign carry_w = {maj_b[W-2:0], plus_one};

    // Both words are doubled for the next iteration.
    assign s_nxt = {sum_b[W-2:0], 1'b0};
    assign c_nxt = {carry_w[W-2:0], 1'b0};
endmodule

// File: rtl/srt_final_fix.sv
module srt_final_fix #(
    parameter int N = 8,
    parameter int P = 8
) (
    input  logic [N:0]   s_half,
    input  logic [N:0]   c_half,
    input  logic [N-1:0] y,
    input  logic         x_neg,
    input  logic [P-1:0] q_pos,
    input  logic [P-1:0] q_neg,
    output logic [P:0]   q_fix,
    output logic [N:0]   r_fix
);
    logic [N:0] r_raw;
    logic [N:0] y_ext;
    logic [N:0] r_plus;
    logic [N:0] r_minus;
    logic [P:0] q_raw;
    logic       r_neg;
    logic       r_nz;
    logic       r_is_negy;

    always_comb begin
        r_raw     = s_half + c_half;
        y_ext     = {1'b0, y};
        r_plus    = r_raw + y_ext;
        r_minus   = r_raw - y_ext;
        q_raw     = {1'b0, q_pos} - {1'b0, q_neg};
        r_neg     = r_raw[N];
        r_nz      = |r_raw;
        r_is_negy = (r_plus == '0);

        q_fix = q_raw;
        r_fix = r_raw;
        if (!x_neg && r_neg) begin
            q_fix = q_raw - 1'b1;
            r_fix = r_plus;
        end else if (x_neg && r_nz && !r_neg) begin
            q_fix = q_raw + 1'b1;
            r_fix = r_minus;
        end else if (x_neg && r_is_negy) begin
            q_fix = q_raw - 1'b1;
            r_fix = '0;
        end
    end
endmodule

// File: rtl/srt_cs_divider.sv
module srt_cs_divider
    import srt_cs_pkg::*;
#(
    parameter int N = 8,
    parameter int P = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N:0]   dividend,
    input  logic [N-1:0] divisor,
    output logic [P:0]   quotient,
    output logic [N:0]   remainder,
    output logic         done
);
    localparam int W  = N + 3;
    localparam int CW = (P > 1) ? $clog2(P) : 1;

    typedef struct packed {
        logic [W-1:0] s;
        logic [W-1:0] c;
    } cs_word_t;

    phase_e        phase;
    logic [CW-1:0] cnt;
    cs_word_t      cs;
    cs_word_t      cs_nxt;
    logic [N-1:0]  y_q;
    logic          x_neg_q;
    logic [P-1:0]  q_pos;
    logic [P-1:0]  q_neg;
    digit_e        dig;
    logic [P:0]    q_fix;
    logic [N:0]    r_fix;
    logic          idle;

    assign idle = (phase == PH_IDLE);

    srt_digit_sel u_sel (
        .s_top (cs.s[W-1:W-4]),
        .c_top (cs.c[W-1:W-4]),
        .dig   (dig)
    );

    srt_csa_row #(.N(N)) u_row (
        .s_in  (cs.s),
        .c_in  (cs.c),
        .y     (y_q),
        .dig   (dig),
        .s_nxt (cs_nxt.s),
        .c_nxt (cs_nxt.c)
    );

    srt_final_fix #(.N(N), .P(P)) u_fix (
        .s_half (cs.s[N+1:1]),
        .c_half (cs.c[N+1:1]),
        .y      (y_q),
        .x_neg  (x_neg_q),
        .q_pos  (q_pos),
        .q_neg  (q_neg),
        .q_fix  (q_fix),
        .r_fix  (r_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            cs        <= '0;
            y_q       <= '0;
            x_neg_q   <= 1'b0;
            q_pos     <= '0;
            q_neg     <= '0;
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cs.s    <= {dividend[N], dividend, 1'b0};
                        cs.c    <= '0;
                        y_q     <= divisor;
                        x_neg_q <= dividend[N];
                        q_pos   <= '0;
                        q_neg   <= '0;
                        cnt     <= '0;
                        phase   <= PH_ITER;
                    end
                end
                PH_ITER: begin
                    cs    <= cs_nxt;
                    q_pos <= (q_pos << 1) | P'(dig == DIG_POS);
                    q_neg <= (q_neg << 1) | P'(dig == DIG_NEG);
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(P - 1)) begin
                        phase <= PH_FIX;
                    end
                end
                PH_FIX: begin
                    quotient  <= q_fix;
                    remainder <= r_fix;
                    done      <= 1'b1;
                    phase     <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srt_cs_divider_chk.sv
module srt_cs_divider_chk #(
    parameter int N = 8,
    parameter int P = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         idle,
    input logic [N:0]   dividend,
    input logic [N-1:0] divisor,
    input logic [P:0]   quotient,
    input logic [N:0]   remainder,
    input logic         done
);
    localparam int LW = $clog2(P + 2) + 1;
    localparam int WW = N + P + 4;

    logic          active;
    logic [LW-1:0] lat;
    logic [N:0]    xc;
    logic [N-1:0]  yc;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            lat    <= '0;
            xc     <= '0;
            yc     <= '0;
        end else if (start && idle) begin
            active <= 1'b1;
            lat    <= '0;
            xc     <= dividend;
            yc     <= divisor;
        end else if (active) begin
            lat <= lat + 1'b1;
            if (done) active <= 1'b0;
        end
    end

    logic signed [WW-1:0] lhs;
    logic signed [WW-1:0] rhs;
    logic [N:0]           rem_abs;

    always_comb begin
        lhs = $signed({{(WW-N-1){xc[N]}}, xc}) <<< P;
        rhs = $signed({{(WW-P-1){quotient[P]}}, quotient})
              * $signed({{(WW-N){1'b0}}, yc})
              + $signed({{(WW-N-1){remainder[N]}}, remainder});
        rem_abs = ~remainder + 1'b1;
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> (active && lat == LW'(P + 1)));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_identity_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (lhs == rhs));

    p_rem_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !xc[N]) |-> (!remainder[N] && remainder < {1'b0, yc}));

    p_rem_nonpos_r6: assert property (@(posedge clk) disable iff (rst)
        (done && xc[N]) |-> (remainder == '0 || (remainder[N] && rem_abs < {1'b0, yc})));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind srt_cs_divider srt_cs_divider_chk #(.N(N), .P(P)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .idle      (idle),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done)
);

// File: tb/srt_cs_divider_tb.sv
`timescale 1ns/1ps
module srt_cs_divider_tb;
    localparam int N = 8;
    localparam int P = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N:0]   dividend = '0;
    logic [N-1:0] divisor = '0;
    logic [P:0]   quotient;
    logic [N:0]   remainder;
    logic         done;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    srt_cs_divider #(.N(N), .P(P)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .done      (done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_q(input longint xv, input longint yv);
        return (xv * (longint'(1) <<< P)) / yv;
    endfunction

    function automatic longint ref_r(input longint xv, input longint yv);
        return (xv * (longint'(1) <<< P)) - ref_q(xv, yv) * yv;
    endfunction

    function automatic longint q_now();
        return longint'($signed(quotient));
    endfunction

    function automatic longint r_now();
        return longint'($signed(remainder));
    endfunction

    // Called at the negedge that follows the accepting edge.
    task automatic finish_and_check(input longint xv, input longint yv,
                                    input longint old_q, input longint old_r, input bit chk_hold);
        repeat (P) @(negedge clk);
        check("R1 done not early", longint'(done), 0);
        if (chk_hold) begin
            check("R8 quotient held", q_now(), old_q);
            check("R8 remainder held", r_now(), old_r);
        end
        @(negedge clk);
        check("R1 done at P+1", longint'(done), 1);
        check("R4 quotient", q_now(), ref_q(xv, yv));
        check("R4 remainder", r_now(), ref_r(xv, yv));
        if (xv >= 0) check("R5 remainder sign", longint'(r_now() >= 0 && r_now() < yv), 1);
        else         check("R6 remainder sign", longint'(r_now() <= 0 && -r_now() < yv), 1);
    endtask

    task automatic launch(input longint xv, input longint yv);
        @(negedge clk);
        dividend = xv[N:0];
        divisor  = yv[N-1:0];
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_one(input longint xv, input longint yv);
        launch(xv, yv);
        finish_and_check(xv, yv, 0, 0, 1'b0);
        @(negedge clk);
        check("R2 done single cycle", longint'(done), 0);
    endtask

    task automatic test_reset();
        check("R8 reset quotient", q_now(), 0);
        check("R8 reset remainder", r_now(), 0);
        check("R8 reset done", longint'(done), 0);
    endtask

    task automatic test_boundaries();
        run_one(0, 200);
        check("R7 zero dividend quotient", q_now(), 0);
        run_one(-200, 200);
        check("R7 X=-Y quotient", q_now(), -(longint'(1) <<< P));
        check("R7 X=-Y remainder", r_now(), 0);
        run_one(199, 200);
        check("R7 X=Y-1 quotient bound", longint'(q_now() <= (longint'(1) <<< P) - 1), 1);
        run_one(-128, 128);
        run_one(127, 128);
        run_one(-1, 255);
        run_one(254, 255);
        run_one(-64, 128);
        check("R6 exact negative remainder", r_now(), 0);
        run_one(1, 128);
        run_one(-37, 171);
    endtask

    task automatic test_random();
        for (int k = 0; k < 40; k++) begin
            longint yv;
            longint xv;
            yv = longint'(1 <<< (N - 1)) + longint'($urandom % (1 << (N - 1)));
            xv = longint'($urandom) % (2 * yv) - yv;
            run_one(xv, yv);
        end
    endtask

    task automatic test_busy_start();
        launch(93, 150);
        repeat (3) @(negedge clk);
        dividend = 9'h1F0;
        divisor  = 8'hC0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (P - 4) @(negedge clk);
        check("R3 done not early after busy start", longint'(done), 0);
        @(negedge clk);
        check("R3 done timing kept", longint'(done), 1);
        check("R3 quotient of first operands", q_now(), ref_q(93, 150));
        check("R3 remainder of first operands", r_now(), ref_r(93, 150));
        @(negedge clk);
        check("R3 no second completion", longint'(done), 0);
        repeat (P + 2) @(negedge clk);
        check("R3 still idle", longint'(done), 0);
    endtask

    task automatic test_back_to_back();
        longint q1;
        longint r1;
        launch(-77, 133);
        finish_and_check(-77, 133, 0, 0, 1'b0);
        q1 = q_now();
        r1 = r_now();
        dividend = 9'd101;
        divisor  = 8'd229;
        start    = 1'b1;
        check("R9 start in done cycle", longint'(done), 1);
        @(negedge clk);
        start = 1'b0;
        check("R2 done dropped", longint'(done), 0);
        finish_and_check(101, 229, q1, r1, 1'b1);
        check("R9 back-to-back quotient", q_now(), ref_q(101, 229));
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_boundaries();
        test_busy_start();
        test_back_to_back();
        test_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule